// File: doc/BRIEF.md
# Software Standby Power-Mode Sequencer

This block sequences the clock and power modes of a small microcontroller. When the CPU issues a sleep request while standby is enabled, the block enters software standby. If the watchdog or the bus-release settings forbid entry, it refuses and the chip keeps running. In software standby the master clock and the oscillator are switched off and the peripherals are held in reset. The retention enable stays high, so CPU registers and RAM keep their contents.

The block leaves standby in one of three ways:
- **Interrupt wake.** A non-maskable interrupt, or an enabled and unmasked IRQ, turns the oscillator back on. The block then waits a programmable settling count before it releases the clock and reports an interrupt wake.
- **Reset wake.** A low level on the external reset pin brings the clock back at once. A reset wake is reported when the pin returns high.
- **Hardware standby.** A low level on the hardware-standby pin forces a separate hardware-standby state from any state. This state drops retention, and it is left through the reset-wake path.

The wake cause is held until the CPU acknowledges it. The oscillator, the core and the retention logic are modelled only as enable outputs. Analog settling is replaced by a cycle counter.

Top module: `pdc_standby_ctrl`

## Requirements
- R1: After reset the block is in run mode. Outputs are clk_en_o=1, osc_en_o=1, periph_rst_o=0, retain_o=1, sw_standby_o=0, hw_standby_o=0, and wake_cause_o=0.
- R2: A one-cycle sleep_req_i, sampled with standby_en_i=1 and entry not otherwise blocked, puts the block in software standby at the next edge. With standby_en_i=0 the block stays in run mode.
- R3: In software standby the outputs are clk_en_o=0, osc_en_o=0, periph_rst_o=1, retain_o=1, sw_standby_o=1, hw_standby_o=0.
- R4: A sleep request sampled with both wdog_mode_i=1 and wdog_run_i=1 is refused, and the block stays in run mode.
- R5: A sleep request sampled with bus_release_en_i=1 is refused, and the block stays in run mode.
- R6: In standby, irq_i[k] wakes the block only when irq_en_i[k]=1 and irq_mask_i[k]=0. nmi_i always wakes it. A non-qualifying IRQ leaves the block in standby.
- R7: After a wake, the block spends exactly 2^(settle_sel_i+4) cycles in the settling phase, with settle_sel_i latched at standby entry. During this phase osc_en_o=1, clk_en_o=0, periph_rst_o=1, retain_o=1 and sw_standby_o=1. The block then returns to run mode.
- R8: On return from a settle, wake_cause_o becomes 2 if nmi_i was high at the wake edge, and 1 otherwise. NMI therefore outranks any IRQ raised in the same cycle.
- R9: ext_reset_ni low in run, standby or settle gives clk_en_o=1, osc_en_o=1, periph_rst_o=1 at the next edge, even with an interrupt pending. When the pin returns high, the block enters run mode with wake_cause_o=3.
- R10: hw_standby_ni low forces hardware standby at the next edge, from any state and over every other input. Outputs are clk_en_o=0, osc_en_o=0, periph_rst_o=1, retain_o=0, hw_standby_o=1. Releasing the pin enters the reset-wake state.
- R11: A nonzero wake_cause_o holds its value until wake_ack_i is sampled high, and reads 0 from the following cycle.
- R12: The settle counter restarts from zero on each standby entry, on each reset wake and on reset, so a settle that a reset aborted does not shorten the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sleep_req_i | input | 1 | Sleep request pulse from the CPU |
| standby_en_i | input | 1 | Software standby enable bit |
| settle_sel_i | input | 3 | Settling count select, 2^(n+4) cycles |
| wdog_mode_i | input | 1 | Watchdog is in watchdog (not interval) mode |
| wdog_run_i | input | 1 | Watchdog timer running |
| bus_release_en_i | input | 1 | Bus release permitted |
| nmi_i | input | 1 | Non-maskable interrupt level |
| irq_i | input | 3 | IRQ request levels |
| irq_en_i | input | 3 | Per-IRQ enable bits |
| irq_mask_i | input | 3 | Per-IRQ mask from the CPU, 1 = masked |
| ext_reset_ni | input | 1 | External reset pin, active low |
| hw_standby_ni | input | 1 | Hardware standby pin, active low |
| wake_ack_i | input | 1 | CPU acknowledge of the wake cause |
| clk_en_o | output | 1 | Master clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| periph_rst_o | output | 1 | Reset to DMA and peripheral modules |
| retain_o | output | 1 | Register and RAM retention enable |
| sw_standby_o | output | 1 | In software standby or settling |
| hw_standby_o | output | 1 | In hardware standby |
| wake_cause_o | output | 2 | 0 none, 1 IRQ, 2 NMI, 3 reset |

## Verification
The assertions assume that every pin input is already synchronous to clk_i and stable across each edge. The bench drives all inputs one time unit after a rising edge. The assertions also assume that settle_sel_i changes only while the block is running. The bench keeps the select constant from the sleep request until the block returns to run mode. It chooses random select values from 0 to 3, which bounds each settle to 128 cycles. A reset or hardware-standby pin is held at least one full cycle, so every level the properties depend on is seen by the state machine.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SSTBY, ST_SETTLE, ST_RSTWK, ST_HSTBY
  } pdc_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_IRQ  = 2'd1,
    CAUSE_NMI  = 2'd2,
    CAUSE_RST  = 2'd3
  } wake_cause_e;
endpackage

// File: rtl/pdc_entry_gate.sv
module pdc_entry_gate (
  input  logic sleep_req_i,
  input  logic standby_en_i,
  input  logic wdog_mode_i,
  input  logic wdog_run_i,
  input  logic bus_release_en_i,
  output logic enter_o
);
  logic wdog_block, bus_block;

  // running watchdog in watchdog mode would fire during standby
  assign wdog_block = wdog_mode_i & wdog_run_i;
  assign bus_block  = bus_release_en_i;
  assign enter_o    = sleep_req_i & standby_en_i & ~wdog_block & ~bus_block;
endmodule

// File: rtl/pdc_wake_detect.sv
module pdc_wake_detect #(
  parameter int NUM_IRQ = 3
) (
  input  logic               nmi_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  output logic               wake_o,
  output logic               nmi_win_o
);
  logic [NUM_IRQ-1:0] irq_ok;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_qual
    assign irq_ok[k] = irq_i[k] & irq_en_i[k] & ~irq_mask_i[k];
  end

  assign wake_o    = nmi_i | (|irq_ok);
  assign nmi_win_o = nmi_i;  // NMI outranks any simultaneous IRQ
endmodule

// File: rtl/pdc_settle_timer.sv
module pdc_settle_timer #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int MAX_SH = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W  = MAX_SH + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q, limit;

  assign limit  = ONE << (BASE_LOG2 + int'(sel_q));
  assign done_o = en_i && (cnt_q == limit - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sel_q <= sel_i;
    end else if (en_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R7: sequencer must stop counting once the limit is reached
  a_r7_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < limit);
endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
  import pdc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enter_i,
  input  logic        wake_i,
  input  logic        nmi_win_i,
  input  logic        ext_reset_ni,
  input  logic        hw_standby_ni,
  input  logic        settle_done_i,
  output pdc_state_e  state_o,
  output logic        clr_o,
  output logic        settle_en_o,
  output wake_cause_e ev_cause_o
);
  pdc_state_e state_q, state_d;
  logic       src_nmi_q;

  always_comb begin
    state_d = state_q;
    if (!hw_standby_ni) begin
      state_d = ST_HSTBY;
    end else begin
      unique case (state_q)
        ST_RUN:    if (!ext_reset_ni) state_d = ST_RSTWK;
                   else if (enter_i)  state_d = ST_SSTBY;
        ST_SSTBY:  if (!ext_reset_ni) state_d = ST_RSTWK;
                   else if (wake_i)   state_d = ST_SETTLE;
        ST_SETTLE: if (!ext_reset_ni) state_d = ST_RSTWK;
                   else if (settle_done_i) state_d = ST_RUN;
        ST_RSTWK:  if (ext_reset_ni)  state_d = ST_RUN;
        ST_HSTBY:  state_d = ST_RSTWK;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      src_nmi_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SSTBY && state_d == ST_SETTLE) src_nmi_q <= nmi_win_i;
    end
  end

  always_comb begin
    ev_cause_o = CAUSE_NONE;
    if (state_d == ST_RUN) begin
      if (state_q == ST_SETTLE)     ev_cause_o = src_nmi_q ? CAUSE_NMI : CAUSE_IRQ;
      else if (state_q == ST_RSTWK) ev_cause_o = CAUSE_RST;
    end
  end

  assign clr_o       = (state_d != state_q) && (state_d == ST_SSTBY || state_d == ST_RSTWK);
  assign settle_en_o = (state_q == ST_SETTLE);
  assign state_o     = state_q;

  a_r10_hstby_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_standby_ni |=> state_q == ST_HSTBY);

  a_r9_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_standby_ni && !ext_reset_ni && state_q != ST_HSTBY) |=> state_q == ST_RSTWK);

  a_r6_no_spurious_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSTBY && !wake_i && ext_reset_ni && hw_standby_ni) |=> state_q == ST_SSTBY);

  a_r7_wait_for_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !settle_done_i && ext_reset_ni && hw_standby_ni)
      |=> state_q == ST_SETTLE);
endmodule

// File: rtl/pdc_standby_ctrl.sv
module pdc_standby_ctrl
  import pdc_pkg::*;
#(
  parameter int NUM_IRQ   = 3,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               standby_en_i,
  input  logic [SEL_W-1:0]   settle_sel_i,
  input  logic               wdog_mode_i,
  input  logic               wdog_run_i,
  input  logic               bus_release_en_i,
  input  logic               nmi_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               ext_reset_ni,
  input  logic               hw_standby_ni,
  input  logic               wake_ack_i,
  output logic               clk_en_o,
  output logic               osc_en_o,
  output logic               periph_rst_o,
  output logic               retain_o,
  output logic               sw_standby_o,
  output logic               hw_standby_o,
  output logic [1:0]         wake_cause_o
);
  logic        enter, wake, nmi_win, tmr_clr, tmr_en, tmr_done;
  pdc_state_e  state;
  wake_cause_e ev_cause, cause_q;

  pdc_entry_gate u_gate (
    .sleep_req_i      (sleep_req_i),
    .standby_en_i     (standby_en_i),
    .wdog_mode_i      (wdog_mode_i),
    .wdog_run_i       (wdog_run_i),
    .bus_release_en_i (bus_release_en_i),
    .enter_o          (enter)
  );

  pdc_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .nmi_i      (nmi_i),
    .irq_i      (irq_i),
    .irq_en_i   (irq_en_i),
    .irq_mask_i (irq_mask_i),
    .wake_o     (wake),
    .nmi_win_o  (nmi_win)
  );

  pdc_settle_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .sel_i  (settle_sel_i),
    .done_o (tmr_done)
  );

  pdc_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (enter),
    .wake_i        (wake),
    .nmi_win_i     (nmi_win),
    .ext_reset_ni  (ext_reset_ni),
    .hw_standby_ni (hw_standby_ni),
    .settle_done_i (tmr_done),
    .state_o       (state),
    .clr_o         (tmr_clr),
    .settle_en_o   (tmr_en),
    .ev_cause_o    (ev_cause)
  );

  // cause register: a new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cause_q <= CAUSE_NONE;
    else if (ev_cause != CAUSE_NONE) cause_q <= ev_cause;
    else if (wake_ack_i)             cause_q <= CAUSE_NONE;
  end
  assign wake_cause_o = cause_q;

  always_comb begin
    {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b110100;
    unique case (state)
      ST_RUN:    {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b110100;
      ST_SSTBY:  {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b001110;
      ST_SETTLE: {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b011110;
      ST_RSTWK:  {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b111100;
      ST_HSTBY:  {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b001001;
      default:   {clk_en_o, osc_en_o, periph_rst_o, retain_o, sw_standby_o, hw_standby_o} = 6'b110100;
    endcase
  end

  // R2 R4 R5: standby is only ever entered from a qualified request
  a_r2_entry_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_standby_o) |-> $past(sleep_req_i && standby_en_i && !bus_release_en_i
                                  && !(wdog_mode_i && wdog_run_i)));

  a_r11_cause_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q != CAUSE_NONE && !wake_ack_i && ev_cause == CAUSE_NONE) |=> $stable(cause_q));

  a_r3_retain_in_sw_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_standby_o |-> (retain_o && !clk_en_o && periph_rst_o));
endmodule

// File: tb/pdc_standby_ctrl_tb_top.sv
module pdc_standby_ctrl_tb_top;
  localparam logic [5:0] P_RUN = 6'b110100;
  localparam logic [5:0] P_SST = 6'b001110;
  localparam logic [5:0] P_SET = 6'b011110;
  localparam logic [5:0] P_RWK = 6'b111100;
  localparam logic [5:0] P_HST = 6'b001001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 0, standby_en = 0, wdog_mode = 0, wdog_run = 0, bus_rel = 0;
  logic [2:0] sel = 0, irq = 0, irq_en = 0, irq_mask = 0;
  logic       nmi = 0, ext_rst_n = 1, hwsb_n = 1, ack = 0;
  logic       clk_en, osc_en, prst, retain, sw_sb, hw_sb;
  logic [1:0] cause;
  logic [5:0] outs;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pdc_standby_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .standby_en_i(standby_en),
    .settle_sel_i(sel), .wdog_mode_i(wdog_mode), .wdog_run_i(wdog_run),
    .bus_release_en_i(bus_rel), .nmi_i(nmi), .irq_i(irq), .irq_en_i(irq_en),
    .irq_mask_i(irq_mask), .ext_reset_ni(ext_rst_n), .hw_standby_ni(hwsb_n),
    .wake_ack_i(ack), .clk_en_o(clk_en), .osc_en_o(osc_en), .periph_rst_o(prst),
    .retain_o(retain), .sw_standby_o(sw_sb), .hw_standby_o(hw_sb), .wake_cause_o(cause)
  );
  assign outs = {clk_en, osc_en, prst, retain, sw_sb, hw_sb};

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    report();
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit entry_ok(bit en, bit wm, bit wr, bit br);
    return en && !br && !(wm && wr);
  endfunction

  function automatic int settle_len(int s);
    return 1 << (s + 4);
  endfunction

  function automatic bit irq_qualifies(logic [2:0] r, logic [2:0] e, logic [2:0] m);
    return |(r & e & ~m);
  endfunction

  task automatic try_sleep(string req, bit en, bit wm, bit wr, bit br, logic [2:0] s, output bit entered);
    standby_en = en; wdog_mode = wm; wdog_run = wr; bus_rel = br; sel = s;
    sleep_req = 1; step(); sleep_req = 0;
    entered = entry_ok(en, wm, wr, br);
    chk(req, outs, entered ? P_SST : P_RUN);
  endtask

  // counts samples spent settling, starting at the current one
  task automatic measure_settle(string req, int s);
    int c = 0;
    while (outs == P_SET && c < 5000) begin c++; step(); end
    chk(req, c, settle_len(s));
    chk(req, outs, P_RUN);
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
    chk("R11 ack clears cause", cause, 0);
  endtask

  initial begin
    bit ent;
    process_setup();
    // R1 reset state
    #1; chk("R1 reset outputs", outs, P_RUN);
    step(); rst_n = 1; step();
    chk("R1 outputs after reset", outs, P_RUN);
    chk("R1 cause after reset", cause, 0);

    // R2 disabled, R4, R5 refusals
    try_sleep("R2 standby_en clear", 0, 0, 0, 0, 3'd0, ent);
    try_sleep("R4 watchdog interlock", 1, 1, 1, 0, 3'd0, ent);
    try_sleep("R5 bus release enabled", 1, 0, 0, 1, 3'd0, ent);
    try_sleep("R2 entry accepted", 1, 1, 0, 0, 3'd0, ent);
    chk("R3 standby outputs", outs, P_SST);

    // R6 masked and disabled IRQs do not wake
    irq = 3'b010; irq_en = 3'b010; irq_mask = 3'b010; step(); step();
    chk("R6 masked irq", outs, P_SST);
    irq_en = 3'b000; irq_mask = 3'b000; step(); step();
    chk("R6 disabled irq", outs, P_SST);
    irq_en = 3'b010; step(); irq = 0;
    chk("R6 qualified irq wakes", outs, P_SET);
    measure_settle("R7 settle sel0", 0);
    chk("R8 irq cause", cause, 1);
    step(); step(); step();
    chk("R11 cause held", cause, 1);
    do_ack();

    // R8 NMI beats IRQ in the same cycle
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd1, ent);
    nmi = 1; irq = 3'b111; irq_en = 3'b111; step(); nmi = 0; irq = 0;
    measure_settle("R7 settle sel1", 1);
    chk("R8 nmi priority", cause, 2);
    do_ack();

    // R9 reset wins over NMI in standby
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd0, ent);
    ext_rst_n = 0; nmi = 1; step(); nmi = 0;
    chk("R9 immediate clock on reset", outs, P_RWK);
    step(); step(); step();
    chk("R9 held in reset wake", outs, P_RWK);
    ext_rst_n = 1; step();
    chk("R9 run after reset", outs, P_RUN);
    chk("R9 reset cause", cause, 3);
    do_ack();

    // R12 aborted settle does not shorten the next
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd2, ent);
    nmi = 1; step(); nmi = 0;
    repeat (20) step();
    ext_rst_n = 0; step(); step(); ext_rst_n = 1; step();
    chk("R12 reset aborts settle", outs, P_RUN);
    do_ack();
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd2, ent);
    nmi = 1; step(); nmi = 0;
    measure_settle("R12 full settle after abort", 2);
    do_ack();

    // R10 hardware standby from run, standby and settle, over everything
    hwsb_n = 0; ext_rst_n = 0; nmi = 1; step(); nmi = 0; ext_rst_n = 1;
    chk("R10 hw standby from run", outs, P_HST);
    hwsb_n = 1; step();
    chk("R10 release to reset wake", outs, P_RWK);
    step();
    chk("R10 run after release", outs, P_RUN);
    chk("R9 reset cause after hw standby", cause, 3);
    do_ack();
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd3, ent);
    hwsb_n = 0; step(); hwsb_n = 1;
    chk("R10 hw standby from sw standby", outs, P_HST);
    step(); step(); do_ack();
    try_sleep("R2 entry", 1, 0, 0, 0, 3'd3, ent);
    nmi = 1; step(); nmi = 0; step(); step();
    hwsb_n = 0; step(); hwsb_n = 1;
    chk("R10 hw standby from settle", outs, P_HST);
    step(); step(); do_ack();

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [2:0] s, r, e, m;
      int kind;
      s = 3'($urandom_range(0, 3));
      try_sleep("R2 R4 R5 random entry", ($urandom % 4) != 0, $urandom % 2,
                $urandom % 2, ($urandom % 4) == 0, s, ent);
      if (!ent) continue;
      kind = $urandom % 3;
      r = 3'($urandom); e = 3'($urandom); m = 3'($urandom);
      if (kind == 0) begin
        irq = r; irq_en = e; irq_mask = m; step(); irq = 0;
        if (!irq_qualifies(r, e, m)) begin
          chk("R6 random non-qualifying irq", outs, P_SST);
          nmi = 1; step(); nmi = 0;
          measure_settle("R7 random settle", s);
          chk("R8 random nmi cause", cause, 2);
        end else begin
          measure_settle("R7 random settle", s);
          chk("R8 random irq cause", cause, 1);
        end
      end else if (kind == 1) begin
        nmi = 1; irq = r; irq_en = e; irq_mask = m; step(); nmi = 0; irq = 0;
        measure_settle("R7 random settle", s);
        chk("R8 random nmi priority", cause, 2);
      end else begin
        ext_rst_n = 0; nmi = $urandom % 2; step(); nmi = 0;
        chk("R9 random reset wake", outs, P_RWK);
        ext_rst_n = 1; step();
        chk("R9 random reset cause", cause, 3);
      end
      do_ack();
    end
    report();
  end

  task automatic process_setup();
    process::self().srandom(32'd1234);
  endtask
endmodule